// File: doc/BRIEF.md
# Capture Timer Channel

This block is a single timer channel that counts edges of a selectable clock and can latch the running count when a capture input changes. A register port sets the channel's mode, compare value and interrupt mask. The same port issues the start, stop and re-arm commands and reads back the captured values, the counter and the event flags.

The count clock is one of five prescaled copies of the system clock or one of three external clock inputs. It can be counted on either edge and can be ANDed with an external level. The count runs only while a small state machine is in CLK_RUN. The machine has three states: CLK_OFF (clock disabled), CLK_RUN (counting) and CLK_HOLD (enabled but paused). It has four transitions: GO (CLK_OFF to CLK_RUN on an enable command), HALT (any state to CLK_OFF on a disable command or on a disable-on-RB load), PAUSE (CLK_RUN to CLK_HOLD on a stop-on-RB load) and RESUME (CLK_HOLD to CLK_RUN on any trigger). A trigger is a software trigger, a chosen edge of one of two trigger pins, or an RC match with restart enabled. Every trigger clears the counter and re-arms the capture sequence. A trigger in CLK_OFF clears the counter but does not start it.

Register map (addr): 0 write command / read counter; 1 mode; 2 RA (read); 3 RB (read); 4 RC; 5 status (read clears); 6 write sets mask bits / read mask; 7 write clears mask bits / read returns zero.

Top module: `capture_timer`

## Requirements
- R1: Mode bits [2:0] pick the count clock: 0..4 are the system clock divided by 2, 8, 32, 128 and 1024, and 5, 6, 7 are external inputs xc[0], xc[1], xc[2]. Mode bit 3 = 0 counts rising edges and 1 counts falling edges. The counter advances by exactly one per counted edge while in CLK_RUN.
- R2: Mode bits [5:4] gate the selected clock: 0 = no gating, and 1, 2, 3 AND it with xc[0], xc[1], xc[2]. A gated-off clock produces no counts.
- R3: A write to address 0 acts per bit: bit 0 enables (GO), bit 1 disables (HALT) and takes priority over bit 0, and bit 2 clears the counter (RESUME from CLK_HOLD). Zero bits have no effect. The counter does not change outside CLK_RUN except when a trigger clears it.
- R4: A count whose next value equals RC, RA or RB sets status bit 4, 2 or 3. With mode bit 11 set, the RC match loads 0 instead of RC, so the count period is RC ticks. With bit 11 clear, counting continues.
- R5: A count from all-ones to zero sets status bit 0.
- R6: Mode bits [13:12] (RA) and [15:14] (RB) choose the capture edge of tio_a: 0 none, 1 rising, 2 falling, 3 both. RA loads first. RB loads only after an RA load since the last trigger or RB load. Loads set status bit 5 (RA) and bit 6 (RB).
- R7: A load into RA or RB whose previous value has not been read sets status bit 1.
- R8: An RB load with mode bit 6 set pauses counting (PAUSE). With mode bit 7 set, it disables the clock (HALT), and only an enable command restarts it.
- R9: Mode bits [9:8] choose the trigger edge (0 none, 1 rising, 2 falling, 3 both). Mode bit 10 picks the trigger pin (0 tio_a, 1 tio_b). A trigger edge clears the counter and sets status bit 7.
- R10: Reading address 5 returns the eight status bits and clears them. An event in the same cycle stays set.
- R11: Writing ones to address 6 sets mask bits and writing ones to address 7 clears them. Zero bits leave the mask unchanged. irq is high when any status bit is set with its mask bit set.
- R12: After reset the state is CLK_OFF, and counter, mode, RA, RB, RC, status, mask and irq are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| xc | input | 3 | External clock / gate inputs |
| tio_a | input | 1 | Capture input and trigger pin 0 |
| tio_b | input | 1 | Trigger pin 1 |
| irq | output | 1 | Masked interrupt request |

## Verification
On every cycle the assertions check four things. The counter is frozen outside CLK_RUN unless a trigger clears it, and moves by at most one inside it. RB never changes without a prior RA load. A disable command always reaches CLK_OFF. The mask and overflow flag track their causes, and irq stays low with an empty mask. Only the bench scenarios can show the rest: the exact count totals for each clock source, edge sense and gate level, the RC restart period, the RA-then-RB order with its overrun flag, pause versus disable on RB, trigger pin selection and the clear-on-read status.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    typedef enum logic [1:0] {
        CLK_OFF  = 2'd0,
        CLK_RUN  = 2'd1,
        CLK_HOLD = 2'd2
    } clk_state_e;

    localparam logic [2:0] A_CMD  = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_RA   = 3'd2;
    localparam logic [2:0] A_RB   = 3'd3;
    localparam logic [2:0] A_RC   = 3'd4;
    localparam logic [2:0] A_STS  = 3'd5;
    localparam logic [2:0] A_MSET = 3'd6;
    localparam logic [2:0] A_MCLR = 3'd7;

    typedef struct packed {
        logic [1:0] rb_edge;
        logic [1:0] ra_edge;
        logic       rc_restart;
        logic       trig_src;
        logic [1:0] trig_edge;
        logic       dis_on_rb;
        logic       stop_on_rb;
        logic [1:0] gate;
        logic       inv;
        logic [2:0] clksel;
    } mode_t;

    // 01 rising, 10 falling, 11 either, 00 none
    function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction

endpackage

// File: rtl/ctm_sync.sv
module ctm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign lvl = s2_q;
endmodule

// File: rtl/ctm_clk_sel.sv
module ctm_clk_sel (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       inv,
    input  logic [1:0] gate,
    input  logic [2:0] xc_lvl,
    output logic       tick
);
    localparam int NTAP = 5;
    localparam int TAP [NTAP] = '{0, 2, 4, 6, 9};
    localparam int DIV_W = TAP[NTAP-1] + 1;

    logic [DIV_W-1:0] div_q;
    logic [NTAP-1:0]  tap_lvl;
    logic             src_lvl, gated, cur, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        assign tap_lvl[i] = div_q[TAP[i]];
    end

    always_comb begin
        if (sel < 3'(NTAP)) src_lvl = tap_lvl[sel];
        else                src_lvl = xc_lvl[2'(sel - 3'(NTAP))];
        if (gate == 2'd0)   gated = src_lvl;
        else                gated = src_lvl & xc_lvl[gate - 2'd1];
        cur = gated ^ inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    assign tick = cur & ~prev_q;
endmodule

// File: rtl/ctm_clk_fsm.sv
module ctm_clk_fsm
    import ctm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_cmd,
    input  logic dis_cmd,
    input  logic trig,
    input  logic rb_stop,
    input  logic rb_dis,
    output logic count_ok,
    output logic clk_on
);
    clk_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CLK_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (dis_cmd || rb_dis) begin
            st_d = CLK_OFF;                        // HALT
        end else begin
            unique case (st_q)
                CLK_OFF:  if (en_cmd)  st_d = CLK_RUN;  // GO
                CLK_RUN:  if (rb_stop) st_d = CLK_HOLD; // PAUSE
                CLK_HOLD: if (trig)    st_d = CLK_RUN;  // RESUME
                default:               st_d = CLK_OFF;
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            CLK_RUN:  begin count_ok = 1'b1; clk_on = 1'b1; end
            CLK_HOLD: begin count_ok = 1'b0; clk_on = 1'b1; end
            default:  begin count_ok = 1'b0; clk_on = 1'b0; end
        endcase
    end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import ctm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic [2:0]       xc,
    input  logic             tio_a,
    input  logic             tio_b,
    output logic             irq
);
    localparam int NSRC = 8;
    localparam int MODE_W = $bits(mode_t);

    mode_t            mode_q;
    logic [CNT_W-1:0] cnt_q, ra_q, rb_q, rc_q, cnt_inc;
    logic [NSRC-1:0]  sts_q, mask_q, evt;
    logic             ra_loaded, ra_unread, rb_unread;
    logic [2:0]       xc_lvl;
    logic [1:0]       tio_lvl, tio_prev_q, tio_rise, tio_fall;
    logic             tick, count_ok, clk_on, tick_ok;
    logic             wr_cmd, en_cmd, dis_cmd, sw_trg, ext_trg, trig, rc_rst;
    logic             ra_hit, rb_hit, rc_hit, ovf, ld_a, ld_b, lovr;

    ctm_sync #(.W(3)) u_xc_sync  (.clk(clk), .rst_n(rst_n), .din(xc), .lvl(xc_lvl));
    ctm_sync #(.W(2)) u_tio_sync (.clk(clk), .rst_n(rst_n), .din({tio_b, tio_a}), .lvl(tio_lvl));

    ctm_clk_sel u_sel (
        .clk(clk), .rst_n(rst_n), .sel(mode_q.clksel), .inv(mode_q.inv),
        .gate(mode_q.gate), .xc_lvl(xc_lvl), .tick(tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tio_prev_q <= '0;
        else        tio_prev_q <= tio_lvl;
    end
    assign tio_rise = tio_lvl & ~tio_prev_q;
    assign tio_fall = ~tio_lvl & tio_prev_q;

    // command decode
    assign wr_cmd  = wr_en && (addr == A_CMD);
    assign en_cmd  = wr_cmd && wdata[0];
    assign dis_cmd = wr_cmd && wdata[1];
    assign sw_trg  = wr_cmd && wdata[2];

    // event detection
    assign ext_trg = edge_hit(mode_q.trig_edge, tio_rise[mode_q.trig_src], tio_fall[mode_q.trig_src]);
    assign tick_ok = tick && count_ok;
    assign cnt_inc = cnt_q + 1'b1;
    assign rc_hit  = tick_ok && (cnt_inc == rc_q);
    assign ra_hit  = tick_ok && (cnt_inc == ra_q);
    assign rb_hit  = tick_ok && (cnt_inc == rb_q);
    assign ovf     = tick_ok && (cnt_q == '1);
    assign rc_rst  = rc_hit && mode_q.rc_restart;
    assign trig    = sw_trg || ext_trg || rc_rst;
    assign ld_a    = edge_hit(mode_q.ra_edge, tio_rise[0], tio_fall[0]) && !ra_loaded;
    assign ld_b    = edge_hit(mode_q.rb_edge, tio_rise[0], tio_fall[0]) && ra_loaded;
    assign lovr    = (ld_a && ra_unread) || (ld_b && rb_unread);
    assign evt     = {ext_trg, ld_b, ld_a, rc_hit, rb_hit, ra_hit, lovr, ovf};

    ctm_clk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .dis_cmd(dis_cmd), .trig(trig),
        .rb_stop(ld_b && mode_q.stop_on_rb), .rb_dis(ld_b && mode_q.dis_on_rb),
        .count_ok(count_ok), .clk_on(clk_on)
    );

    // counter and capture sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ra_q      <= '0;
            rb_q      <= '0;
            ra_loaded <= 1'b0;
            ra_unread <= 1'b0;
            rb_unread <= 1'b0;
        end else begin
            if (trig)         cnt_q <= '0;
            else if (tick_ok) cnt_q <= cnt_inc;

            if (ld_a) ra_q <= cnt_q;
            if (ld_b) rb_q <= cnt_q;

            if (trig)      ra_loaded <= 1'b0;
            else if (ld_a) ra_loaded <= 1'b1;
            else if (ld_b) ra_loaded <= 1'b0;

            if (ld_a)                             ra_unread <= 1'b1;
            else if (rd_en && addr == A_RA)       ra_unread <= 1'b0;
            if (ld_b)                             rb_unread <= 1'b1;
            else if (rd_en && addr == A_RB)       rb_unread <= 1'b0;
        end
    end

    // programmable registers, status and mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            rc_q   <= '0;
            sts_q  <= '0;
            mask_q <= '0;
        end else begin
            if (wr_en && addr == A_MODE) mode_q <= mode_t'(wdata[MODE_W-1:0]);
            if (wr_en && addr == A_RC)   rc_q   <= wdata;
            if (wr_en && addr == A_MSET) mask_q <= mask_q | wdata[NSRC-1:0];
            if (wr_en && addr == A_MCLR) mask_q <= mask_q & ~wdata[NSRC-1:0];
            sts_q <= ((rd_en && addr == A_STS) ? '0 : sts_q) | evt;
        end
    end

    assign irq = |(sts_q & mask_q);

    always_comb begin
        unique case (addr)
            A_CMD:   rdata = cnt_q;
            A_MODE:  rdata = CNT_W'(mode_q);
            A_RA:    rdata = ra_q;
            A_RB:    rdata = rb_q;
            A_RC:    rdata = rc_q;
            A_STS:   rdata = CNT_W'(sts_q);
            A_MSET:  rdata = CNT_W'(mask_q);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker
    import ctm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [CNT_W-1:0] wdata,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] rb_q,
    input logic [7:0]       sts_q,
    input logic [7:0]       mask_q,
    input logic             run,
    input logic             clk_on,
    input logic             trig,
    input logic             ra_loaded,
    input logic             irq
);
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run) && !$past(trig)) |-> $stable(cnt_q)); // R3

    AST_CNT_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(trig)) |-> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R1

    AST_RB_AFTER_RA: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rb_q) |-> $past(ra_loaded)); // R6

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CMD && wdata[1]) |=> !clk_on); // R3

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MSET) |=> ((mask_q & $past(wdata[7:0])) == $past(wdata[7:0]))); // R11

    AST_MASK_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 8'h00) |-> !irq); // R11

    AST_WRAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == '1 && cnt_q == '0 && !$past(trig)) |-> sts_q[0]); // R5
endmodule

bind capture_timer ctm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt_q(cnt_q), .rb_q(rb_q), .sts_q(sts_q), .mask_q(mask_q), .run(count_ok),
    .clk_on(clk_on), .trig(trig), .ra_loaded(ra_loaded), .irq(irq)
);

// File: tb/sim_capture_timer.sv
module sim_capture_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic [2:0]  xc = 3'd0;
    logic        tio_a = 1'b0, tio_b = 1'b0;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    logic [15:0] v;

    always #5 clk = ~clk;

    capture_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .xc(xc), .tio_a(tio_a), .tio_b(tio_b), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] mode;
        logic [15:0] rc;
        logic        xc1;
        logic [7:0]  pulses;
        logic [15:0] exp_cnt;
        logic [7:0]  exp_sts;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{16'h0005, 16'd100, 1'b0, 8'd5,  16'd5, 8'h00},
        '{16'h000D, 16'd100, 1'b0, 8'd7,  16'd7, 8'h00},
        '{16'h0805, 16'd4,   1'b0, 8'd10, 16'd2, 8'h10},
        '{16'h0005, 16'd4,   1'b0, 8'd6,  16'd6, 8'h10},
        '{16'h0025, 16'd100, 1'b0, 8'd4,  16'd0, 8'h00},
        '{16'h0025, 16'd100, 1'b1, 8'd4,  16'd4, 8'h00}
    };
    localparam string VTAG [NV] = '{"R1", "R1", "R4", "R4", "R2", "R2"};

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input logic [15:0] act, input int lo, input int hi);
        n_chk++;
        if (int'(act) < lo || int'(act) > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_xc0(input int n);
        for (int i = 0; i < n; i++) begin
            xc[0] = 1'b1; settle(3);
            xc[0] = 1'b0; settle(3);
        end
        settle(6);
    endtask

    task automatic pulse_a();
        tio_a = 1'b1; settle(3); tio_a = 1'b0; settle(8);
    endtask

    task automatic pulse_b();
        tio_b = 1'b1; settle(3); tio_b = 1'b0; settle(8);
    endtask

    task automatic start(input logic [15:0] mode, input logic [15:0] rc, input logic [15:0] cmd);
        wr(3'd4, rc);
        wr(3'd1, mode);
        settle(3);
        wr(3'd0, cmd);
        rd(3'd5, v);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R12 reset state
        rd(3'd0, v); chk("R12 counter", v, 16'h0);
        rd(3'd1, v); chk("R12 mode", v, 16'h0);
        rd(3'd5, v); chk("R12 status", v, 16'h0);
        chk("R12 irq", {15'd0, irq}, 16'h0);

        // table of vectors: external clock xc0, edge sense, gating, RC compare
        for (int i = 0; i < NV; i++) begin
            xc[1] = VEC[i].xc1;
            start(VEC[i].mode, VEC[i].rc, 16'h0005);
            pulse_xc0(int'(VEC[i].pulses));
            rd(3'd0, v); chk({VTAG[i], " count"}, v, VEC[i].exp_cnt);
            rd(3'd5, v); chk({VTAG[i], " status"}, v, {8'h00, VEC[i].exp_sts});
        end
        xc[1] = 1'b0;

        // R5 wrap with divide-by-2: RC=FFF0, RA=RB=0 also match at wrap (R4)
        start(16'h0000, 16'hFFF0, 16'h0005);
        settle(131200);
        rd(3'd5, v); chk("R5 overflow status", v, 16'h001D);

        // R1 prescaled rates
        start(16'h0001, 16'd1000, 16'h0005);
        settle(160);
        rd(3'd0, v); chk_rng("R1 divide-by-8", v, 18, 22);
        start(16'h0004, 16'd1000, 16'h0005);
        settle(3072);
        rd(3'd0, v); chk_rng("R1 divide-by-1024", v, 2, 4);

        // R6 capture order RA then RB on rising edges
        start(16'h5005, 16'd1000, 16'h0005);
        pulse_xc0(3); pulse_a(); pulse_xc0(2); pulse_a();
        rd(3'd5, v); chk("R6 load flags", v, 16'h0060);
        rd(3'd2, v); chk("R6 RA value", v, 16'd3);
        rd(3'd3, v); chk("R6 RB value", v, 16'd5);
        // R7 overrun on an unread RA
        pulse_a(); pulse_a(); pulse_a();
        rd(3'd5, v); chk("R7 overrun", v, 16'h0062);

        // R6 RB ignored until RA has loaded
        start(16'h4005, 16'd1000, 16'h0004);
        rd(3'd3, v);
        pulse_xc0(2); pulse_a();
        rd(3'd5, v); chk("R6 RB without RA status", v, 16'h0000);
        rd(3'd3, v); chk("R6 RB without RA value", v, 16'd5);

        // R8 stop on RB load, then software trigger restarts
        start(16'h5045, 16'd1000, 16'h0004);
        pulse_xc0(2); pulse_a(); pulse_xc0(1); pulse_a();
        pulse_xc0(4);
        rd(3'd0, v); chk("R8 paused count", v, 16'd3);
        wr(3'd0, 16'h0004);
        pulse_xc0(2);
        rd(3'd0, v); chk("R8 resumed count", v, 16'd2);

        // R8 disable on RB load: trigger alone does not restart
        start(16'h5085, 16'd1000, 16'h0004);
        pulse_a(); pulse_a();
        pulse_xc0(2);
        wr(3'd0, 16'h0004);
        pulse_xc0(2);
        rd(3'd0, v); chk("R8 disabled count", v, 16'd0);
        wr(3'd0, 16'h0001);
        pulse_xc0(3);
        rd(3'd0, v); chk("R8 re-enabled count", v, 16'd3);

        // R9 external trigger on tio_b rising; tio_a ignored
        start(16'h0505, 16'd1000, 16'h0005);
        pulse_xc0(4);
        pulse_a();
        rd(3'd0, v); chk("R9 wrong pin ignored", v, 16'd4);
        pulse_b();
        rd(3'd0, v); chk("R9 trigger clears count", v, 16'd0);
        rd(3'd5, v); chk("R9 trigger flag", v, 16'h0080);
        rd(3'd5, v); chk("R10 status cleared by read", v, 16'h0000);

        // R11 mask and interrupt
        wr(3'd6, 16'h0010);
        start(16'h0005, 16'd3, 16'h0005);
        chk("R11 irq idle", {15'd0, irq}, 16'h0);
        pulse_xc0(3);
        chk("R11 irq on RC match", {15'd0, irq}, 16'h1);
        wr(3'd6, 16'h0000);
        chk("R11 zero write no effect", {15'd0, irq}, 16'h1);
        wr(3'd7, 16'h0010);
        chk("R11 mask cleared", {15'd0, irq}, 16'h0);
        wr(3'd6, 16'h0010);
        chk("R11 mask set again", {15'd0, irq}, 16'h1);
        rd(3'd5, v);
        settle(1);
        chk("R10 irq drops after read", {15'd0, irq}, 16'h0);

        // R3 command bits: disable beats enable, zero write ignored
        wr(3'd0, 16'h0003);
        pulse_xc0(2);
        rd(3'd0, v); chk("R3 disable priority", v, 16'd3);
        wr(3'd0, 16'h0000);
        pulse_xc0(2);
        rd(3'd0, v); chk("R3 zero command", v, 16'd3);
        wr(3'd0, 16'h0001);
        pulse_xc0(1);
        rd(3'd0, v); chk("R3 enable resumes", v, 16'd4);

        finish_run();
    end
endmodule